// File: doc/BRIEF.md
# Simultaneous Two-Channel Sample Serializer

This block is the digital back end of a two-channel converter whose channels are sampled at the same instant. A converter core, outside this block, presents two 12-bit results in parallel. The block captures both results together and shifts them out on a single serial line as one 32-bit frame. It runs entirely on the serial clock that the receiver supplies. A frame starts on the first falling serial-clock edge after chip select goes low. The capture happens on that same edge, and the frame carries channel A first and then channel B. Each channel occupies a 16-bit slot made of four zero bits followed by its twelve data bits, most significant bit first.

Two ways of operating come out of the same logic.
- **Triggered use:** the host lowers chip select once per frame and raises it afterwards.
- **Continuous use:** the host holds chip select low. After each frame the block inserts one idle clock, during which the busy flag is low, and then captures a fresh sample pair. One frame period is therefore 33 serial clocks.

Raising chip select or asserting the power-down input clears the sequencer at once, without waiting for a clock edge. The power-down input also aborts any frame in progress. The serial output is modelled as a data bit plus a separate drive-enable, so that it stays synthesizable.

The sequencer has three states:
- `ST_IDLE`: held while chip select is high or power-down is asserted.
- `ST_SHIFT`: one of the 32 bit times of a frame.
- `ST_GAP`: the idle clock between frames.

Its transitions are:
- *start*: `ST_IDLE` to `ST_SHIFT`. It loads the sample pair on the first falling edge after the clear is released.
- *step*: `ST_SHIFT` to `ST_SHIFT`. The 5-bit bit index counts down from 31.
- *finish*: `ST_SHIFT` to `ST_GAP`. It is taken on the falling edge after bit index 0.
- *restart*: `ST_GAP` to `ST_SHIFT`. It loads a new pair.
- *clear*: any state to `ST_IDLE`. It is asynchronous, on chip select high or power-down high.

Top module: `pair_frame_tx`

## Requirements
- R1: While `cs_n` is high, `sdo_oe`, `conv_busy` and `sdo` are all 0. Raising `cs_n` forces these values immediately, without waiting for a clock edge.
- R2: On the first falling `sclk` edge after `cs_n` goes low (with `pwr_dn` low), `samp_a` and `samp_b` are captured together. On that same edge, `conv_busy` and `sdo_oe` go to 1, and `sdo_oe` stays 1 whenever `conv_busy` is 1.
- R3: A frame is 32 bits. The falling edge numbered k (k=1..32, counting from the capture edge as 1) drives bit 32-k of the word {4'b0, A[11:0], 4'b0, B[11:0]}. The word's bits 31..28 and 15..12 are therefore always 0.
- R4: `sdo`, `conv_busy` and `sdo_oe` change only on falling `sclk` edges unless a clear occurs. They are steady from each rising edge until the next falling edge.
- R5: `conv_busy` is high for exactly 32 falling-edge intervals per frame. It falls on the 33rd falling edge counted from the capture edge.
- R6: With `cs_n` held low, the edge on which `conv_busy` falls sets `sdo` to 0 and keeps `sdo_oe` at 1. The next falling edge captures a new pair and raises `conv_busy` again, so frames repeat every 33 clocks.
- R7: While `pwr_dn` is high, `sdo_oe` and `conv_busy` are 0, and asserting it forces this immediately. After `pwr_dn` falls, the next falling edge starts a fresh frame from bit 31 with a newly captured pair.
- R8: Changes on `samp_a` and `samp_b` after the capture edge have no effect on the frame being shifted.
- R9: Raising `cs_n` in the middle of a frame abandons that frame. The next low period of `cs_n` starts a new, complete frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the receiver; the block acts on its falling edge |
| cs_n | input | 1 | Active-low select; high clears the block asynchronously |
| pwr_dn | input | 1 | Power-down; high clears and aborts asynchronously |
| samp_a | input | 12 | Channel A result from the converter core |
| samp_b | input | 12 | Channel B result from the converter core |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Drive enable for the serial data pin |
| conv_busy | output | 1 | High while a frame is being shifted |

## Verification
On every clock, the bound checker confirms the following:
- Chip select high and power-down high each silence the outputs.
- `conv_busy` never rises without the drive enable.
- The pad positions of both slots carry zeros.
- `conv_busy` never stays high longer than one frame.
- Each fall of `conv_busy` leaves the line at zero and is followed by a restart.

Some behaviour only the bench scenarios can show, because it needs a reference value:
- the actual data bits of each channel, in order;
- that the sample pair is captured on the right edge and is immune to later input changes;
- the immediate, clockless effect of chip select and power-down in mid-frame;
- that a fresh frame follows an abort.

// File: rtl/pft_pkg.sv
package pft_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/pft_packer.sv
module pft_packer #(
    parameter int DATA_W = 12,
    parameter int PAD_W  = 4,
    parameter int NCH    = 2,
    localparam int SLOT_W  = DATA_W + PAD_W,
    localparam int FRAME_W = NCH * SLOT_W
) (
    input  logic [NCH*DATA_W-1:0] samples,
    output logic [FRAME_W-1:0]    word
);

    // Channel 0 sits in the top slot and is shifted out first.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_slot
        assign word[FRAME_W-1-ch*SLOT_W -: SLOT_W] =
            {{PAD_W{1'b0}}, samples[(NCH-ch)*DATA_W-1 -: DATA_W]};
    end

endmodule

// File: rtl/pft_seq.sv
module pft_seq
    import pft_pkg::*;
#(
    parameter int FRAME_W = 32,
    localparam int IDX_W  = $clog2(FRAME_W)
) (
    input  logic             sclk,
    input  logic             rst_any,
    output logic             load,
    output logic             active_nx,
    output logic [IDX_W-1:0] idx_nx,
    output logic             status,
    output logic             drive_en
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(FRAME_W - 1);

    seq_state_e       state_q, state_nx;
    logic [IDX_W-1:0] idx_q;

    // Next-state and bit-index decode.
    always_comb begin
        state_nx = state_q;
        idx_nx   = idx_q;
        load     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_GAP: begin
                state_nx = ST_SHIFT;
                idx_nx   = TOP_IDX;
                load     = 1'b1;
            end
            ST_SHIFT: begin
                if (idx_q == '0) begin
                    state_nx = ST_GAP;
                    idx_nx   = '0;
                end else begin
                    idx_nx   = idx_q - 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                idx_nx   = '0;
            end
        endcase
    end

    assign active_nx = (state_nx == ST_SHIFT);

    // State register.
    always_ff @(negedge sclk or posedge rst_any) begin
        if (rst_any) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_nx;
            idx_q   <= idx_nx;
        end
    end

    // Registered flag outputs.
    always_ff @(negedge sclk or posedge rst_any) begin
        if (rst_any) begin
            status   <= 1'b0;
            drive_en <= 1'b0;
        end else begin
            status   <= active_nx;
            drive_en <= 1'b1;
        end
    end

endmodule

// File: rtl/pft_shift.sv
module pft_shift #(
    parameter int FRAME_W = 32,
    localparam int IDX_W  = $clog2(FRAME_W)
) (
    input  logic               sclk,
    input  logic               rst_any,
    input  logic               load,
    input  logic               active_nx,
    input  logic [IDX_W-1:0]   idx_nx,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               sdo
);

    logic [FRAME_W-1:0] hold_q;

    always_ff @(negedge sclk or posedge rst_any) begin
        if (rst_any) begin
            hold_q <= '0;
            sdo    <= 1'b0;
        end else if (load) begin
            hold_q <= frame_in;
            sdo    <= frame_in[idx_nx];
        end else begin
            sdo    <= active_nx ? hold_q[idx_nx] : 1'b0;
        end
    end

endmodule

// File: rtl/pair_frame_tx.sv
module pair_frame_tx #(
    parameter int DATA_W = 12,
    parameter int PAD_W  = 4
) (
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              pwr_dn,
    input  logic [DATA_W-1:0] samp_a,
    input  logic [DATA_W-1:0] samp_b,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              conv_busy
);

    localparam int NCH     = 2;
    localparam int FRAME_W = NCH * (DATA_W + PAD_W);
    localparam int IDX_W   = $clog2(FRAME_W);

    logic               rst_any;
    logic               load;
    logic               active_nx;
    logic [IDX_W-1:0]   idx_nx;
    logic [FRAME_W-1:0] word;

    // Deselect and power-down both clear everything asynchronously.
    assign rst_any = cs_n | pwr_dn;

    pft_packer #(.DATA_W(DATA_W), .PAD_W(PAD_W), .NCH(NCH)) u_packer (
        .samples ({samp_a, samp_b}),
        .word    (word)
    );

    pft_seq #(.FRAME_W(FRAME_W)) u_seq (
        .sclk      (sclk),
        .rst_any   (rst_any),
        .load      (load),
        .active_nx (active_nx),
        .idx_nx    (idx_nx),
        .status    (conv_busy),
        .drive_en  (sdo_oe)
    );

    pft_shift #(.FRAME_W(FRAME_W)) u_shift (
        .sclk      (sclk),
        .rst_any   (rst_any),
        .load      (load),
        .active_nx (active_nx),
        .idx_nx    (idx_nx),
        .frame_in  (word),
        .sdo       (sdo)
    );

endmodule

// File: rtl/pft_checker.sv
module pft_checker #(
    parameter int DATA_W = 12,
    parameter int PAD_W  = 4
) (
    input logic sclk,
    input logic cs_n,
    input logic pwr_dn,
    input logic sdo,
    input logic sdo_oe,
    input logic conv_busy
);

    localparam int SLOT_W  = DATA_W + PAD_W;
    localparam int FRAME_W = 2 * SLOT_W;
    localparam int POS_W   = $clog2(FRAME_W + 1);

    logic             rst_any;
    logic [POS_W-1:0] pos_q;

    assign rst_any = cs_n | pwr_dn;

    // Counts falling edges already spent with the busy flag high.
    always_ff @(negedge sclk or posedge rst_any) begin
        if (rst_any) pos_q <= '0;
        else         pos_q <= conv_busy ? pos_q + 1'b1 : '0;
    end

    p_off_r1: assert property (@(posedge sclk)
        cs_n |-> (!sdo_oe && !conv_busy && !sdo));

    p_busy_oe_r2: assert property (@(negedge sclk) disable iff (rst_any)
        conv_busy |-> sdo_oe);

    p_pad_zero_r3: assert property (@(negedge sclk) disable iff (rst_any)
        (conv_busy && ((pos_q < POS_W'(PAD_W)) ||
                       (pos_q >= POS_W'(SLOT_W) && pos_q < POS_W'(SLOT_W + PAD_W))))
        |-> !sdo);

    p_busy_len_r5: assert property (@(negedge sclk) disable iff (rst_any)
        conv_busy |-> (pos_q < POS_W'(FRAME_W)));

    p_gap_low_r6: assert property (@(negedge sclk) disable iff (rst_any)
        $fell(conv_busy) |-> (!sdo && sdo_oe));

    p_restart_r6: assert property (@(negedge sclk) disable iff (rst_any)
        $fell(conv_busy) |=> conv_busy);

    p_pwr_off_r7: assert property (@(posedge sclk)
        pwr_dn |-> (!sdo_oe && !conv_busy));

endmodule

bind pair_frame_tx pft_checker #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_chk (
    .sclk      (sclk),
    .cs_n      (cs_n),
    .pwr_dn    (pwr_dn),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .conv_busy (conv_busy)
);

// File: tb/pair_frame_tx_tb_top.sv
`timescale 1ns/1ps
module pair_frame_tx_tb_top;

    logic        sclk = 1'b0;
    logic        cs_n = 1'b0;
    logic        pwr_dn = 1'b0;
    logic [11:0] sa = '0;
    logic [11:0] sb = '0;
    logic        sdo, sdo_oe, conv_busy;

    always #2.5 sclk = ~sclk;

    pair_frame_tx dut_i (
        .sclk (sclk), .cs_n (cs_n), .pwr_dn (pwr_dn),
        .samp_a (sa), .samp_b (sb),
        .sdo (sdo), .sdo_oe (sdo_oe), .conv_busy (conv_busy)
    );

    typedef struct {
        logic  d;
        logic  b;
        logic  o;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act{sdo,busy,oe}=%b exp=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: pops one expected item per rising edge, then checks R4 steadiness.
    initial begin
        forever begin
            @(posedge sclk);
            #0.2;
            if (q.size() > 0) begin
                exp_t e;
                logic [2:0] snap;
                e = q.pop_front();
                snap = {sdo, conv_busy, sdo_oe};
                chk(e.tag, snap, {e.d, e.b, e.o});
                #2.0;
                if (!cs_n && !pwr_dn) chk("R4 steady high phase", {sdo, conv_busy, sdo_oe}, snap);
            end
        end
    end

    // Driver: sets inputs after a rising edge, pushes the outputs expected after the next falling edge.
    task automatic cyc(input logic c, input logic s, input logic [11:0] a, input logic [11:0] b,
                       input logic ed, input logic eb, input logic eo, input string tag);
        exp_t e;
        @(posedge sclk);
        #1;
        cs_n = c; pwr_dn = s; sa = a; sb = b;
        e.d = ed; e.b = eb; e.o = eo; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic frame_part(input logic [11:0] a, input logic [11:0] b,
                              input logic [11:0] fa, input logic [11:0] fb, input int n);
        logic [31:0] w;
        w = {4'h0, a, 4'h0, b};
        cyc(1'b0, 1'b0, a, b, w[31], 1'b1, 1'b1, "R2 capture edge");
        for (int k = 1; k < n; k++)
            cyc(1'b0, 1'b0, fa, fb, w[31-k], 1'b1, 1'b1, "R3 R8 frame bit");
    endtask

    task automatic frame(input logic [11:0] a, input logic [11:0] b,
                         input logic [11:0] fa, input logic [11:0] fb);
        frame_part(a, b, fa, fb, 32);
        cyc(1'b0, 1'b0, fa, fb, 1'b0, 1'b0, 1'b1, "R5 R6 idle clock");
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++)
            cyc(1'b1, 1'b0, 12'h000, 12'h000, 1'b0, 1'b0, 1'b0, "R1 deselected");
    endtask

    task automatic abort_cs();
        exp_t e;
        @(posedge sclk);
        #1;
        cs_n = 1'b1;
        e.d = 1'b0; e.b = 1'b0; e.o = 1'b0; e.tag = "R9 abort by select";
        q.push_back(e);
        #0.5;
        chk("R1 R9 immediate clear", {sdo, conv_busy, sdo_oe}, 3'b000);
    endtask

    task automatic abort_pd();
        exp_t e;
        @(posedge sclk);
        #1;
        pwr_dn = 1'b1;
        e.d = 1'b0; e.b = 1'b0; e.o = 1'b0; e.tag = "R7 power-down";
        q.push_back(e);
        #0.5;
        chk("R7 immediate abort", {1'b0, conv_busy, sdo_oe}, 3'b000);
    endtask

    initial begin
        repeat (100000) @(posedge sclk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #0.1 cs_n = 1'b1;
        #1;
        chk("R1 reset state", {sdo, conv_busy, sdo_oe}, 3'b000);
        idle(3);
        // Triggered use, one frame per select.
        frame(12'hABC, 12'h123, 12'hFFF, 12'h000);
        idle(2);
        frame(12'hFFF, 12'hFFF, 12'h000, 12'h000);
        idle(2);
        // Continuous use, select held low.
        frame(12'h5A5, 12'hA5A, 12'h0F0, 12'hF0F);
        frame(12'h001, 12'h800, 12'hFFF, 12'hFFF);
        frame(12'h000, 12'hFFF, 12'h333, 12'hCCC);
        idle(2);
        // Select raised mid-frame.
        frame_part(12'h7E1, 12'h18E, 12'h000, 12'h000, 10);
        abort_cs();
        idle(1);
        frame(12'h9C3, 12'h3C9, 12'h111, 12'h222);
        idle(1);
        // Power-down mid-frame in continuous use.
        frame_part(12'h456, 12'h789, 12'h000, 12'h000, 20);
        abort_pd();
        cyc(1'b0, 1'b1, 12'h000, 12'h000, 1'b0, 1'b0, 1'b0, "R7 held down");
        frame(12'hC0F, 12'h0FE, 12'h5A5, 12'h5A5);
        idle(2);
        wait (q.size() == 0);
        repeat (3) @(posedge sclk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule